// File: doc/BRIEF.md
# Read Burst Output Sequencer with Burst Stop

This block is the device-side read data path of a double-data-rate memory. It decodes the command pins on every rising clock edge. A read launches a burst whose data appears a programmed number of cycles (the read latency) after the read edge. The block drives the data and strobe output enables and the strobe level. It also supplies the beat index that addresses an external data source, which returns the two beats of each clock cycle.

A burst-stop command cuts a running read burst short. The data and strobe outputs go to high impedance exactly read-latency cycles after the stop edge. A stop that arrives during a write burst, or during a read issued with auto-precharge, is undefined in that context. Such a stop has no effect and raises a one-cycle illegal flag. A stop with no burst in progress is ignored silently.

Each clock cycle carries two beats: the rising half and the falling half. A burst of length BL therefore occupies BL/2 cycles. The mode inputs must be held stable while bursts are in flight.

Top module: `rbs_read_seq`

## Requirements
- R1: A command is decoded only from pins sampled at a rising edge with `cs_n` low. The encodings are `{ras_n,cas_n,we_n}`: 3'b101 read, 3'b100 write, 3'b110 burst stop. Every other value, and any edge with `cs_n` high, does nothing.
- R2: `mode_bl` selects the burst length: 2'b01 = 2 beats, 2'b10 = 4 beats, 2'b11 = 8 beats (2'b00 acts as 2 beats). A read burst drives `dq_oe` high for BL/2 consecutive cycles.
- R3: `mode_cl` (value 2 or 3) is the read latency. `dq_oe` first rises in the state that follows the rising edge `mode_cl` cycles after the read edge.
- R4: In the cycle just before the first data cycle, `dqs_oe` is high and `dqs_out` is low (preamble). During data cycles `dqs_out` is high in the first half and low in the second, so it toggles once per beat.
- R5: In the k-th data cycle of a burst, `beat_idx` equals 2k. `dq_rise`/`dq_fall` carry `src_rise`/`src_fall`. Outside data cycles both are zero.
- R6: A burst stop during a read without auto-precharge clears `dq_oe`, `dqs_oe` and `dqs_out` from the state after the edge `mode_cl` cycles after the stop. With BL 4 and latency 3, a stop one cycle after the read leaves only the first data cycle (beats 0 and 1).
- R7: A burst stop on any of the edges 1 to BL/2+1 after a write raises `illegal_stop` for the one cycle after the stop edge. It changes no output enable.
- R8: A burst stop while a read with `auto_pre` set is in flight raises `illegal_stop` for one cycle, and that burst completes in full.
- R9: A burst stop with no read or write burst in progress changes nothing and leaves `illegal_stop` low.
- R10: The stop works for every burst length, including BL 8, where it truncates the burst at the same latency.
- R11: Synchronous active-low reset clears all enables, the strobe and `illegal_stop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands sampled on rising edges |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe pin of the command |
| cas_n | input | 1 | Column strobe pin of the command |
| we_n | input | 1 | Write-enable pin of the command |
| auto_pre | input | 1 | Auto-precharge flag sampled with a read or write |
| mode_bl | input | 2 | Burst-length code |
| mode_cl | input | CL_W | Read latency in cycles |
| src_rise | input | DQ_W | Source data for the even beat at `beat_idx` |
| src_fall | input | DQ_W | Source data for the odd beat after it |
| beat_idx | output | BEAT_W | Index of the even beat being driven |
| dq_rise | output | DQ_W | Data for the rising half of the cycle |
| dq_fall | output | DQ_W | Data for the falling half of the cycle |
| dq_oe | output | 1 | Output enable for all data bits |
| dqs_oe | output | 1 | Output enable for all strobe pins |
| dqs_out | output | 1 | Strobe level in the first half of the cycle |
| illegal_stop | output | 1 | One-cycle pulse for a stop in an undefined context |

## Verification
The bench builds the block with its defaults: 16-bit data, bursts of up to 8 beats and a read latency of up to 3. This makes both latencies and all three burst lengths reachable. A stop can land at every distance from its read, and an 8-beat burst can be truncated at the same latency as a 4-beat one. With a 6-slot pipeline, stops issued before the first data cycle and during the burst are both exercised.

// File: rtl/rbs_pkg.sv
// Package: command codes shared by the read burst sequencer modules.
// Assumes one command per rising edge, decoded from the four command pins.
package rbs_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_STOP  = 2'd3
    } rbs_cmd_e;

    // Number of clock cycles a burst occupies for a burst-length code.
    function automatic int pairs_of(input logic [1:0] code);
        case (code)
            2'b10:   return 2;
            2'b11:   return 4;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/rbs_cmd_decode.sv
// Command and mode decoder.
// Turns the sampled pins into one command and converts the mode codes into
// a burst length in cycles and a clamped read latency.
// Assumes the mode inputs are stable while bursts are in flight.
module rbs_cmd_decode #(
    parameter int MAX_BL = 8,
    parameter int MAX_CL = 3,
    localparam int CNT_W = $clog2(MAX_BL / 2 + 1),
    localparam int CL_W  = $clog2(MAX_CL + 1)
) (
    input  logic             cs_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic [1:0]       mode_bl,
    input  logic [CL_W-1:0]  mode_cl,
    output rbs_pkg::rbs_cmd_e cmd,
    output logic [CNT_W-1:0] pairs,
    output logic [CL_W-1:0]  cl_eff
);
    import rbs_pkg::*;

    // Pin decode; deselect and unknown codes become NOP.
    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b101:  cmd = CMD_READ;
                3'b100:  cmd = CMD_WRITE;
                3'b110:  cmd = CMD_STOP;
                default: cmd = CMD_NOP;
            endcase
        end
    end

    // Burst length in cycles, never above what the pipeline holds.
    always_comb begin
        int p;
        p = pairs_of(mode_bl);
        if (p > MAX_BL / 2) p = MAX_BL / 2;
        pairs = CNT_W'(p);
    end

    // Read latency clamped to the supported range.
    always_comb begin
        if (int'(mode_cl) < 2)           cl_eff = CL_W'(2);
        else if (int'(mode_cl) > MAX_CL) cl_eff = CL_W'(MAX_CL);
        else                             cl_eff = mode_cl;
    end

endmodule

// File: rtl/rbs_write_track.sv
// Write burst window tracker.
// Marks the edges during which a write burst is in progress, so that a
// burst stop there can be reported as undefined. Write data itself is
// handled elsewhere. The window covers edges 1 to pairs+1 after the write.
module rbs_write_track #(
    parameter int MAX_BL = 8,
    localparam int CNT_W = $clog2(MAX_BL / 2 + 1),
    localparam int WIN_W = $clog2(MAX_BL / 2 + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_go,
    input  logic [CNT_W-1:0] pairs,
    output logic             wr_busy
);
    logic [WIN_W-1:0] win_cnt;

    // Load the window on a write, count it down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)             win_cnt <= '0;
        else if (wr_go)         win_cnt <= WIN_W'(pairs) + WIN_W'(1);
        else if (win_cnt != '0) win_cnt <= win_cnt - WIN_W'(1);
    end

    assign wr_busy = (win_cnt != '0);

    p_write_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> wr_busy);

endmodule

// File: rtl/rbs_slot_pipe.sv
// Output slot pipeline.
// Slot j holds what the outputs will show j+1 edges after the edge that
// wrote it. A read fills its data slots from latency-1 onward and a
// preamble slot just before them. A valid stop clears every slot from
// latency-1 onward, so the outputs go quiet exactly latency edges later.
// Assumes no stop and read on the same edge (one command per edge).
module rbs_slot_pipe #(
    parameter int MAX_BL = 8,
    parameter int MAX_CL = 3,
    localparam int DEPTH  = MAX_CL - 1 + MAX_BL / 2,
    localparam int PAIR_W = $clog2(MAX_BL / 2),
    localparam int CNT_W  = $clog2(MAX_BL / 2 + 1),
    localparam int CL_W   = $clog2(MAX_CL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_go,
    input  logic              rd_ap,
    input  logic              stop_go,
    input  logic [CNT_W-1:0]  pairs,
    input  logic [CL_W-1:0]   cl,
    output logic              out_dq,
    output logic              out_pre,
    output logic [PAIR_W-1:0] out_pair,
    output logic              rd_busy,
    output logic              rd_ap_busy
);
    logic [DEPTH-1:0]  s_dq, s_pre, s_ap;
    logic [DEPTH-1:0]  nx_dq, nx_pre, nx_ap;
    logic [PAIR_W-1:0] s_pair  [DEPTH];
    logic [PAIR_W-1:0] nx_pair [DEPTH];
    logic              q_ap;

    // Next slot contents: shift toward the output, then stop, then load.
    always_comb begin
        int lo;
        lo = int'(cl) - 1;
        nx_dq  = s_dq  >> 1;
        nx_pre = s_pre >> 1;
        nx_ap  = s_ap  >> 1;
        for (int j = 0; j < DEPTH - 1; j++) nx_pair[j] = s_pair[j + 1];
        nx_pair[DEPTH - 1] = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (stop_go && j >= lo) begin
                nx_dq[j]   = 1'b0;
                nx_pre[j]  = 1'b0;
                nx_ap[j]   = 1'b0;
                nx_pair[j] = '0;
            end
            if (rd_go) begin
                if (j >= lo && j < lo + int'(pairs)) begin
                    nx_dq[j]   = 1'b1;
                    nx_pre[j]  = 1'b0;
                    nx_ap[j]   = rd_ap;
                    nx_pair[j] = PAIR_W'(j - lo);
                end else if (j == lo - 1 && !nx_dq[j]) begin
                    nx_pre[j] = 1'b1;
                end
            end
        end
    end

    // Slot registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_dq  <= '0;
            s_pre <= '0;
            s_ap  <= '0;
            for (int j = 0; j < DEPTH; j++) s_pair[j] <= '0;
        end else begin
            s_dq  <= nx_dq;
            s_pre <= nx_pre;
            s_ap  <= nx_ap;
            for (int j = 0; j < DEPTH; j++) s_pair[j] <= nx_pair[j];
        end
    end

    // Output stage: the state driven onto the pins this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_dq   <= 1'b0;
            out_pre  <= 1'b0;
            out_pair <= '0;
            q_ap     <= 1'b0;
        end else begin
            out_dq   <= s_dq[0];
            out_pre  <= s_pre[0];
            out_pair <= s_pair[0];
            q_ap     <= s_ap[0];
        end
    end

    assign rd_busy    = out_dq | (|s_dq);
    assign rd_ap_busy = (out_dq & q_ap) | (|(s_dq & s_ap));

    p_preamble_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_dq) |-> ($past(out_pre) && !$past(out_dq)));

endmodule

// File: rtl/rbs_read_seq.sv
// Read burst output sequencer with burst stop (top).
// Decodes commands, schedules read bursts into the slot pipeline, judges
// each burst stop as valid, undefined or ignored, and drives the data and
// strobe pins. The data source is combinational, addressed by beat_idx.
// Assumes the mode inputs stay stable while bursts are in flight.
module rbs_read_seq #(
    parameter int DQ_W   = 16,
    parameter int MAX_BL = 8,
    parameter int MAX_CL = 3,
    localparam int BEAT_W = $clog2(MAX_BL),
    localparam int PAIR_W = $clog2(MAX_BL / 2),
    localparam int CNT_W  = $clog2(MAX_BL / 2 + 1),
    localparam int CL_W   = $clog2(MAX_CL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              auto_pre,
    input  logic [1:0]        mode_bl,
    input  logic [CL_W-1:0]   mode_cl,
    input  logic [DQ_W-1:0]   src_rise,
    input  logic [DQ_W-1:0]   src_fall,
    output logic [BEAT_W-1:0] beat_idx,
    output logic [DQ_W-1:0]   dq_rise,
    output logic [DQ_W-1:0]   dq_fall,
    output logic              dq_oe,
    output logic              dqs_oe,
    output logic              dqs_out,
    output logic              illegal_stop
);
    import rbs_pkg::*;

    rbs_cmd_e          cmd;
    logic [CNT_W-1:0]  pairs;
    logic [CL_W-1:0]   cl_eff;
    logic              wr_busy, rd_busy, rd_ap_busy;
    logic              stop_go, stop_bad;
    logic              out_dq, out_pre;
    logic [PAIR_W-1:0] out_pair;

    rbs_cmd_decode #(.MAX_BL(MAX_BL), .MAX_CL(MAX_CL)) i_decode (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .mode_bl(mode_bl), .mode_cl(mode_cl),
        .cmd(cmd), .pairs(pairs), .cl_eff(cl_eff)
    );

    rbs_write_track #(.MAX_BL(MAX_BL)) i_wtrack (
        .clk(clk), .rst_n(rst_n), .wr_go(cmd == CMD_WRITE),
        .pairs(pairs), .wr_busy(wr_busy)
    );

    rbs_slot_pipe #(.MAX_BL(MAX_BL), .MAX_CL(MAX_CL)) i_pipe (
        .clk(clk), .rst_n(rst_n),
        .rd_go(cmd == CMD_READ), .rd_ap(auto_pre), .stop_go(stop_go),
        .pairs(pairs), .cl(cl_eff),
        .out_dq(out_dq), .out_pre(out_pre), .out_pair(out_pair),
        .rd_busy(rd_busy), .rd_ap_busy(rd_ap_busy)
    );

    // Classify a stop: undefined context wins, then a live read, else ignore.
    always_comb begin
        stop_bad = (cmd == CMD_STOP) && (wr_busy || rd_ap_busy);
        stop_go  = (cmd == CMD_STOP) && !stop_bad && rd_busy;
    end

    // One-cycle flag for a stop in an undefined context.
    always_ff @(posedge clk) begin
        if (!rst_n) illegal_stop <= 1'b0;
        else        illegal_stop <= stop_bad;
    end

    // Pin drive: data and strobe share one enable decision for all bits.
    always_comb begin
        dq_oe    = out_dq;
        dqs_oe   = out_dq | out_pre;
        dqs_out  = out_dq;
        beat_idx = {out_pair, 1'b0};
        dq_rise  = out_dq ? src_rise : '0;
        dq_fall  = out_dq ? src_fall : '0;
    end

    p_read_cl2_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_READ && cl_eff == CL_W'(2)) |-> ##3 dq_oe);
    p_read_cl3_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_READ && cl_eff == CL_W'(3)) |-> ##4 dq_oe);
    p_stop_cl2_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_go && cl_eff == CL_W'(2)) |-> ##3 (!dq_oe && !dqs_oe));
    p_stop_cl3_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_go && cl_eff == CL_W'(3)) |-> ##4 (!dq_oe && !dqs_oe));
    p_idle_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STOP && !rd_busy && !wr_busy) |=> !illegal_stop);

endmodule

// File: tb/test_rbs_read_seq.sv
// Directed bench for rbs_read_seq: one task per scenario, each checking
// the pins cycle by cycle against values worked out from the requirements.
module test_rbs_read_seq;
    localparam int DQ_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic auto_pre = 1'b0;
    logic [1:0] mode_bl = 2'b10;
    logic [1:0] mode_cl = 2'd3;
    logic [DQ_W-1:0] src_rise, src_fall, dq_rise, dq_fall;
    logic [2:0] beat_idx;
    logic dq_oe, dqs_oe, dqs_out, illegal_stop;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    // Data source model: beat number folded into a marker pattern.
    assign src_rise = 16'hA500 | {13'd0, beat_idx};
    assign src_fall = 16'h5A00 | ({13'd0, beat_idx} + 16'd1);

    rbs_read_seq i_rbs_read_seq (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .auto_pre(auto_pre), .mode_bl(mode_bl), .mode_cl(mode_cl),
        .src_rise(src_rise), .src_fall(src_fall), .beat_idx(beat_idx),
        .dq_rise(dq_rise), .dq_fall(dq_fall), .dq_oe(dq_oe), .dqs_oe(dqs_oe),
        .dqs_out(dqs_out), .illegal_stop(illegal_stop)
    );

    task automatic pins(input logic c, input logic r, input logic a, input logic w);
        cs_n = c; ras_n = r; cas_n = a; we_n = w;
    endtask

    task automatic check(input string tag, input int cyc,
                         input logic [35:0] exp);
        logic [35:0] act;
        act = {dq_oe, dqs_oe, dqs_out, illegal_stop, dq_rise, dq_fall};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    function automatic logic [35:0] expect_of(input bit dq, input bit pre,
                                              input bit ill, input int b);
        logic [15:0] r, f;
        r = dq ? (16'hA500 | 16'(b)) : 16'h0;
        f = dq ? (16'h5A00 | 16'(b + 1)) : 16'h0;
        return {dq, dq | pre, dq, ill, r, f};
    endfunction

    // Read with an optional stop d edges after it (d = 0: no stop).
    // Covers R2-R6, R8, R10.
    task automatic run_read(input logic [1:0] blc, input int cl, input bit ap,
                            input int d, input string tag);
        int pairs;
        pairs = (blc == 2'b11) ? 4 : (blc == 2'b10) ? 2 : 1;
        mode_bl = blc; mode_cl = 2'(cl); auto_pre = ap;
        pins(1'b0, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        pins(1'b1, 1'b1, 1'b1, 1'b1); auto_pre = 1'b0;
        for (int i = 1; i <= 12; i++) begin
            bit dq, pre, ill;
            if (i == d) pins(1'b0, 1'b1, 1'b1, 1'b0);
            else        pins(1'b1, 1'b1, 1'b1, 1'b1);
            @(negedge clk);
            dq  = (i >= cl) && (i < cl + pairs) && (d == 0 || ap || i < d + cl);
            pre = (i == cl - 1);
            ill = ap && (d > 0) && (i == d);
            check(tag, i, expect_of(dq, pre, ill, 2 * (i - cl)));
        end
        pins(1'b1, 1'b1, 1'b1, 1'b1);
    endtask

    // Burst stop d edges after a write: flag only, no enables (R7).
    task automatic run_write_stop(input logic [1:0] blc, input int d);
        mode_bl = blc;
        pins(1'b0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        for (int i = 1; i <= 6; i++) begin
            if (i == d) pins(1'b0, 1'b1, 1'b1, 1'b0);
            else        pins(1'b1, 1'b1, 1'b1, 1'b1);
            @(negedge clk);
            check("R7 stop in write", i, expect_of(1'b0, 1'b0, i == d, 0));
        end
        pins(1'b1, 1'b1, 1'b1, 1'b1);
    endtask

    // One command cycle that must leave every output quiet (R1, R9).
    task automatic run_quiet(input logic c, input logic r, input logic a,
                             input logic w, input string tag);
        mode_cl = 2'd2; mode_bl = 2'b10;
        pins(c, r, a, w);
        @(negedge clk);
        pins(1'b1, 1'b1, 1'b1, 1'b1);
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            check(tag, i, expect_of(1'b0, 1'b0, 1'b0, 0));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset state", 0, expect_of(1'b0, 1'b0, 1'b0, 0));
        rst_n = 1'b1;
        @(negedge clk);
        run_quiet(1'b1, 1'b1, 1'b0, 1'b1, "R1 deselected read");
        run_quiet(1'b0, 1'b0, 1'b1, 1'b1, "R1 other command");
        run_read(2'b10, 3, 1'b0, 0, "R2 R3 R4 R5 BL4 CL3");
        run_read(2'b01, 2, 1'b0, 0, "R2 R3 BL2 CL2");
        run_read(2'b11, 2, 1'b0, 0, "R2 R5 BL8 CL2");
        run_read(2'b11, 3, 1'b0, 0, "R2 BL8 CL3");
        run_read(2'b10, 3, 1'b0, 1, "R6 stop BL4 CL3");
        run_read(2'b10, 2, 1'b0, 2, "R6 stop BL4 CL2");
        run_read(2'b11, 2, 1'b0, 2, "R10 stop BL8 CL2");
        run_read(2'b11, 3, 1'b0, 4, "R10 stop BL8 CL3");
        run_read(2'b10, 3, 1'b1, 1, "R8 stop auto-precharge");
        run_write_stop(2'b10, 2);
        run_write_stop(2'b11, 5);
        run_quiet(1'b0, 1'b1, 1'b1, 1'b0, "R9 idle stop");
        run_read(2'b10, 2, 1'b0, 0, "R2 read after stops");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual hung run, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule